// File: doc/BRIEF.md
# Link power state controller

This block is the device-side keeper of the interface operating state. After power-up or a hardware reset it holds a reset state, in which the host may not touch its registers. After a fixed settling delay it reports itself ready. The host then programs the idle thresholds and asks for the operational state. From there, two things can suspend the interface. A device-side inactivity timer steps it into a light suspend and then a deeper low-power suspend. The host can also suspend it explicitly, into a state that only the host can end.

The current state is always readable in a status register through a simple single-cycle register port. It also drives a state output. Every transition raises a one-cycle event request that carries the new state, so an interrupt or event-ring writer elsewhere can report it.

States and their codes: RESET=0, READY=1, M0 (operational)=2, M1 (device-idle suspend)=3, M2 (low power)=4, M3 (host suspend)=5.

Transitions:
- RESET to READY after the settling delay.
- READY to M0 on a host wake request.
- M0 to M1 on the first idle timeout.
- M1 to M2 on the second idle timeout.
- M1 or M2 to M0 on activity, a doorbell or a host wake request.
- M0, M1 or M2 to M3 on a host suspend request.
- M3 to M0 on a host wake request only.

Register map (word address):
- 0 holds status. Bits [2:0] are the state and bit 8 is the access-error flag.
- 1 holds control and is write-only. Bit 0 is the wake request and bit 1 the suspend request.
- 2 holds the first idle threshold.
- 3 holds the second idle threshold.

Top module: `lpsc_top`

## Requirements
- R1: While reset is asserted the state is RESET (0) and no event is raised. The state becomes READY (1) on exactly the RST_DLY-th rising clock edge after reset is released, and RESET is never re-entered without a hardware reset. State codes are RESET=0, READY=1, M0=2, M1=3, M2=4, M3=5.
- R2: A register write while in RESET changes no register and no state, and it sets the error flag, status bit 8. Outside RESET, writing address 0 with bit 8 set clears the flag.
- R3: While in RESET every register read returns zero.
- R4: In READY, a write to address 1 with bit 0 set moves the state to M0 at that edge. A write with only bit 1 set, activity pulses and doorbell pulses leave READY unchanged.
- R5: In M0 an idle counter is cleared on entry and on every cycle with activity or a doorbell. After IDLE1+1 consecutive idle cycles in M0 the state becomes M1. IDLE1 is the value at address 2.
- R6: After IDLE2+1 consecutive idle cycles in M1 the state becomes M2. IDLE2 is the value at address 3.
- R7: In M1 or M2, an activity or doorbell pulse returns the state to M0 at that edge. M2 is left only for M0 or M3.
- R8: A write to address 1 with bit 1 set and bit 0 clear moves M0, M1 or M2 to M3. In M3, activity, doorbells and idle time have no effect, and only a write with bit 0 set leaves M3, to M0.
- R9: A threshold of zero disables the corresponding idle timeout.
- R10: An event pulse is raised for exactly one cycle in each cycle whose state differs from the previous cycle's, with the event state equal to the new state, and at no other time.
- R11: When causes coincide, a wake request beats a suspend request, which beats activity, which beats an idle timeout.
- R12: Outside RESET, addresses 2 and 3 read back the last written thresholds (low IDLE_W bits). Address 1 reads zero, and address 0 reads the state in bits [2:0] and the error flag in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| phy_act_i | input | 1 | Physical interface activity pulse |
| doorbell_i | input | 1 | Channel doorbell pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the current address |
| link_state_o | output | 3 | Current state code |
| evt_valid_o | output | 1 | State-change event request, one cycle |
| evt_state_o | output | 3 | New state carried by the event |

## Verification
The hardest situations to reach from the ports are coincidences on the exact cycle a threshold expires. One is an activity pulse arriving on the very edge at which M1 would have dropped into M2. Another is a wake and a suspend request landing together with activity. The stimulus gets there by waiting for the event that marks entry into a state and then counting edges from that entry. It then places the competing inputs on the one edge where the idle count equals the threshold. A behavioural model advanced on every edge catches any off-by-one in the counting.

// File: rtl/lpsc_pkg.sv
package lpsc_pkg;

    localparam int unsigned ST_W = 3;

    typedef enum logic [ST_W-1:0] {
        ST_RESET = 3'd0,
        ST_READY = 3'd1,
        ST_M0    = 3'd2,
        ST_M1    = 3'd3,
        ST_M2    = 3'd4,
        ST_M3    = 3'd5
    } lps_state_e;

    // word addresses of the register port
    localparam int unsigned RA_STATUS = 0;
    localparam int unsigned RA_CTRL   = 1;
    localparam int unsigned RA_IDLE1  = 2;
    localparam int unsigned RA_IDLE2  = 3;

    // bit positions
    localparam int unsigned ERR_BIT  = 8;
    localparam int unsigned WAKE_BIT = 0;
    localparam int unsigned SUSP_BIT = 1;

endpackage

// File: rtl/lpsc_regs.sv
module lpsc_regs
    import lpsc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDLE_W    = 16,
    parameter int unsigned DEF_IDLE1 = 1000,
    parameter int unsigned DEF_IDLE2 = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  lps_state_e        state,
    output logic [DATA_W-1:0] rdata,
    output logic              req_wake,
    output logic              req_susp,
    output logic [IDLE_W-1:0] idle1_thr,
    output logic [IDLE_W-1:0] idle2_thr
);

    logic gated;
    logic wr_ok;
    logic sel_status, sel_ctrl, sel_idle1, sel_idle2;
    logic err_q;
    logic unused_wbits;

    assign gated      = (state == ST_RESET);
    assign wr_ok      = wr_en && !gated;
    assign sel_status = (addr == ADDR_W'(RA_STATUS));
    assign sel_ctrl   = (addr == ADDR_W'(RA_CTRL));
    assign sel_idle1  = (addr == ADDR_W'(RA_IDLE1));
    assign sel_idle2  = (addr == ADDR_W'(RA_IDLE2));
    assign unused_wbits = ^wdata;

    // control requests are decoded in the write cycle, no storage
    assign req_wake = wr_ok && sel_ctrl && wdata[WAKE_BIT];
    assign req_susp = wr_ok && sel_ctrl && wdata[SUSP_BIT] && !wdata[WAKE_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle1_thr <= IDLE_W'(DEF_IDLE1);
            idle2_thr <= IDLE_W'(DEF_IDLE2);
        end else if (wr_ok) begin
            if (sel_idle1) idle1_thr <= wdata[IDLE_W-1:0];
            if (sel_idle2) idle2_thr <= wdata[IDLE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_en && gated) begin
            err_q <= 1'b1;
        end else if (wr_ok && sel_status && wdata[ERR_BIT]) begin
            err_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (!gated) begin
            if (sel_status) begin
                rdata[ST_W-1:0] = state;
                rdata[ERR_BIT]  = err_q;
            end else if (sel_idle1) begin
                rdata[IDLE_W-1:0] = idle1_thr;
            end else if (sel_idle2) begin
                rdata[IDLE_W-1:0] = idle2_thr;
            end
        end
    end

endmodule

// File: rtl/lpsc_idle_timer.sv
module lpsc_idle_timer #(
    parameter int unsigned IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              restart_i,
    input  logic              armed_i,
    input  logic [IDLE_W-1:0] thr_i,
    output logic              expire_o
);

    logic [IDLE_W-1:0] cnt_q;
    logic              sat;

    assign sat = (cnt_q == {IDLE_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (act_i || restart_i) begin
            cnt_q <= '0;
        end else if (!sat) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // zero threshold disables; >= tolerates a threshold lowered mid-count
    assign expire_o = armed_i && (thr_i != '0) && (cnt_q >= thr_i) && !act_i;

endmodule

// File: rtl/lpsc_fsm.sv
module lpsc_fsm
    import lpsc_pkg::*;
#(
    parameter int unsigned RST_DLY = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_i,
    input  logic       req_wake_i,
    input  logic       req_susp_i,
    input  logic       expire_i,
    output lps_state_e state_o,
    output logic       chg_o,
    output logic       evt_valid_o,
    output lps_state_e evt_state_o
);

    localparam int unsigned RCNT_W = $clog2(RST_DLY + 1);

    lps_state_e        state_q, state_d;
    logic [RCNT_W-1:0] rcnt_q;
    logic              settle_done;

    assign settle_done = (rcnt_q == RCNT_W'(RST_DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcnt_q <= '0;
        end else if (state_q == ST_RESET && !settle_done) begin
            rcnt_q <= rcnt_q + 1'b1;
        end
    end

    // next state: wake > suspend > activity > timeout
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: if (settle_done) state_d = ST_READY;
            ST_READY: if (req_wake_i) state_d = ST_M0;
            ST_M0: begin
                if (req_susp_i)    state_d = ST_M3;
                else if (expire_i) state_d = ST_M1;
            end
            ST_M1: begin
                if (req_wake_i)      state_d = ST_M0;
                else if (req_susp_i) state_d = ST_M3;
                else if (act_i)      state_d = ST_M0;
                else if (expire_i)   state_d = ST_M2;
            end
            ST_M2: begin
                if (req_wake_i)      state_d = ST_M0;
                else if (req_susp_i) state_d = ST_M3;
                else if (act_i)      state_d = ST_M0;
            end
            ST_M3: if (req_wake_i) state_d = ST_M0;
            default: state_d = ST_RESET;
        endcase
    end

    assign chg_o = (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid_o <= 1'b0;
            evt_state_o <= ST_RESET;
        end else begin
            evt_valid_o <= chg_o;
            if (chg_o) evt_state_o <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/lpsc_top.sv
module lpsc_top
    import lpsc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned IDLE_W    = 16,
    parameter int unsigned RST_DLY   = 16,
    parameter int unsigned DEF_IDLE1 = 1000,
    parameter int unsigned DEF_IDLE2 = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_act_i,
    input  logic              doorbell_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [2:0]        link_state_o,
    output logic              evt_valid_o,
    output logic [2:0]        evt_state_o
);

    lps_state_e        state, evt_state;
    logic              req_wake, req_susp, expire, chg, activity, armed;
    logic [IDLE_W-1:0] idle1_thr, idle2_thr, thr_sel;

    assign activity = phy_act_i || doorbell_i;
    assign armed    = (state == ST_M0) || (state == ST_M1);
    assign thr_sel  = (state == ST_M1) ? idle2_thr : idle1_thr;

    lpsc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_W(IDLE_W),
        .DEF_IDLE1(DEF_IDLE1), .DEF_IDLE2(DEF_IDLE2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
        .state(state), .rdata(reg_rdata_o),
        .req_wake(req_wake), .req_susp(req_susp),
        .idle1_thr(idle1_thr), .idle2_thr(idle2_thr)
    );

    lpsc_idle_timer #(.IDLE_W(IDLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .act_i(activity), .restart_i(chg), .armed_i(armed),
        .thr_i(thr_sel), .expire_o(expire)
    );

    lpsc_fsm #(.RST_DLY(RST_DLY)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .act_i(activity), .req_wake_i(req_wake), .req_susp_i(req_susp),
        .expire_i(expire), .state_o(state), .chg_o(chg),
        .evt_valid_o(evt_valid_o), .evt_state_o(evt_state)
    );

    assign link_state_o = state;
    assign evt_state_o  = evt_state;

endmodule

// File: rtl/lpsc_chk.sv
module lpsc_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        link_state,
    input logic              evt_valid,
    input logic [2:0]        evt_state,
    input logic [DATA_W-1:0] reg_rdata
);

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        link_state <= 3'd5);

    p_reset_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state) == 3'd0 && link_state != 3'd0) |-> link_state == 3'd1);

    p_no_reset_reentry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state) != 3'd0) |-> link_state != 3'd0);

    p_read_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == 3'd0) |-> reg_rdata == '0);

    p_ready_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state) == 3'd1 && link_state != 3'd1) |-> link_state == 3'd2);

    p_m2_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state) == 3'd4 && link_state != 3'd4) |->
        (link_state == 3'd2 || link_state == 3'd5));

    p_m3_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(link_state) == 3'd5 && link_state != 3'd5) |-> link_state == 3'd2);

    p_evt_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state != $past(link_state)) |-> (evt_valid && evt_state == link_state));

    p_evt_only_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> link_state != $past(link_state));

endmodule

bind lpsc_top lpsc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .link_state(link_state_o),
    .evt_valid(evt_valid_o), .evt_state(evt_state_o), .reg_rdata(reg_rdata_o)
);

// File: tb/tb_lpsc_top.sv
module tb_lpsc_top;

    localparam int CLK_PERIOD = 10;
    localparam int RST_DLY    = 5;
    localparam int IDLE_W     = 8;
    localparam int DEF1       = 6;
    localparam int DEF2       = 4;
    localparam int CNT_MAX    = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phy_act = 1'b0;
    logic        doorbell = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  link_state;
    logic        evt_valid;
    logic [2:0]  evt_state;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpsc_top #(
        .ADDR_W(4), .DATA_W(32), .IDLE_W(IDLE_W), .RST_DLY(RST_DLY),
        .DEF_IDLE1(DEF1), .DEF_IDLE2(DEF2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .phy_act_i(phy_act), .doorbell_i(doorbell),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .link_state_o(link_state),
        .evt_valid_o(evt_valid), .evt_state_o(evt_state)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st = 0, m_rcnt = 0, m_cnt = 0, m_thr1 = DEF1, m_thr2 = DEF2;
    int m_err = 0, m_evt = 0, m_evs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rcnt = 0; m_cnt = 0; m_thr1 = DEF1; m_thr2 = DEF2;
            m_err = 0; m_evt = 0; m_evs = 0;
        end else begin
            int  nx, thr;
            bit  a, wake, susp, armed, expd, chg;
            a     = phy_act || doorbell;
            wake  = reg_wr && reg_addr == 1 && m_st != 0 && reg_wdata[0];
            susp  = reg_wr && reg_addr == 1 && m_st != 0 && reg_wdata[1] && !reg_wdata[0];
            thr   = (m_st == 3) ? m_thr2 : m_thr1;
            armed = (m_st == 2 || m_st == 3);
            expd  = armed && thr != 0 && m_cnt >= thr && !a;
            nx = m_st;
            if (m_st == 0)      begin if (m_rcnt == RST_DLY - 1) nx = 1; end
            else if (m_st == 1) begin if (wake) nx = 2; end
            else if (m_st == 2) begin if (susp) nx = 5; else if (expd) nx = 3; end
            else if (m_st == 5) begin if (wake) nx = 2; end
            else begin
                if (wake) nx = 2;
                else if (susp) nx = 5;
                else if (a) nx = 2;
                else if (expd && m_st == 3) nx = 4;
            end
            chg = (nx != m_st);
            if (a || chg) m_cnt = 0; else if (m_cnt < CNT_MAX) m_cnt++;
            if (m_st == 0) m_rcnt++;
            if (reg_wr) begin
                if (m_st == 0) m_err = 1;
                else if (reg_addr == 0 && reg_wdata[8]) m_err = 0;
                else if (reg_addr == 2) m_thr1 = int'(reg_wdata[7:0]);
                else if (reg_addr == 3) m_thr2 = int'(reg_wdata[7:0]);
            end
            m_evt = chg ? 1 : 0;
            if (chg) m_evs = nx;
            m_st = nx;
        end
    end

    function automatic int exp_rdata();
        if (m_st == 0) return 0;
        case (reg_addr)
            4'd0: return (m_err << 8) | m_st;
            4'd2: return m_thr1;
            4'd3: return m_thr2;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "state vs model", int'(link_state), m_st);
            chk("R10", "event valid vs model", int'(evt_valid), m_evt);
            chk("R10", "event state vs model", int'(evt_state), m_evs);
            chk(cur_req, "rdata vs model", int'(reg_rdata), exp_rdata());
        end
    end

    // ---------------- stimulus helpers (start and end at edge+2) ----------------
    task automatic step();
        @(posedge clk); #2;
        reg_wr = 1'b0; phy_act = 1'b0; doorbell = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
        step();
    endtask

    task automatic wr_act(int a, int d);
        phy_act = 1'b1;
        wr(a, d);
    endtask

    task automatic pulse_act();
        phy_act = 1'b1; step();
    endtask

    task automatic pulse_db();
        doorbell = 1'b1; step();
    endtask

    task automatic rd(int a, output int v);
        reg_addr = 4'(a); #1; v = int'(reg_rdata);
    endtask

    task automatic wait_for(int s);
        for (int i = 0; i < 60 && int'(link_state) != s; i++) step();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int v;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "state in reset", int'(link_state), 0);
        chk("R1", "event in reset", int'(evt_valid), 0);
        rst_n = 1'b1;

        cur_req = "R2";
        wr(2, 8'h33);
        rd(0, v); chk("R3", "status read in RESET", v, 0);
        rd(2, v); chk("R3", "idle1 read in RESET", v, 0);
        idle(RST_DLY - 2);
        chk("R1", "still RESET one edge early", int'(link_state), 0);
        idle(1);
        chk("R1", "READY after RST_DLY edges", int'(link_state), 1);
        chk("R10", "event on READY entry", int'(evt_valid), 1);
        chk("R10", "event carries READY", int'(evt_state), 1);
        rd(0, v); chk("R2", "error flag set by RESET write", v, 32'h101);
        rd(2, v); chk("R2", "RESET write ignored", v, DEF1);
        wr(0, 32'h100);
        rd(0, v); chk("R2", "error flag cleared", v, 1);

        cur_req = "R4";
        wr(1, 2);
        chk("R4", "suspend ignored in READY", int'(link_state), 1);
        pulse_act();
        pulse_db();
        chk("R4", "activity ignored in READY", int'(link_state), 1);
        wr(1, 1);
        chk("R4", "wake moves READY to M0", int'(link_state), 2);

        cur_req = "R5";
        idle(DEF1);
        chk("R5", "M0 held for IDLE1 cycles", int'(link_state), 2);
        idle(1);
        chk("R5", "M1 after IDLE1+1 idle cycles", int'(link_state), 3);

        cur_req = "R7";
        pulse_act();
        chk("R7", "activity returns M1 to M0", int'(link_state), 2);

        cur_req = "R5";
        idle(3);
        pulse_act();
        idle(DEF1);
        chk("R5", "activity restarted idle count", int'(link_state), 2);
        idle(1);
        chk("R5", "M1 after restart", int'(link_state), 3);

        cur_req = "R6";
        idle(DEF2);
        chk("R6", "M1 held for IDLE2 cycles", int'(link_state), 3);
        idle(1);
        chk("R6", "M2 after IDLE2+1 idle cycles", int'(link_state), 4);

        cur_req = "R7";
        pulse_db();
        chk("R7", "doorbell returns M2 to M0", int'(link_state), 2);

        cur_req = "R9";
        wr(2, 0);
        idle(20);
        chk("R9", "zero threshold disables timeout", int'(link_state), 2);

        cur_req = "R8";
        wr(1, 2);
        chk("R8", "host suspend to M3", int'(link_state), 5);
        pulse_act();
        pulse_db();
        wr(2, 2);
        idle(10);
        wr(1, 0);
        chk("R8", "M3 ignores activity and idle", int'(link_state), 5);
        wr(1, 1);
        chk("R8", "wake leaves M3 to M0", int'(link_state), 2);

        cur_req = "R11";
        wait_for(3);
        chk("R11", "reached M1", int'(link_state), 3);
        wr_act(1, 3);
        chk("R11", "wake beats suspend", int'(link_state), 2);
        wait_for(3);
        wr_act(1, 2);
        chk("R11", "suspend beats activity", int'(link_state), 5);
        wr(1, 1);
        wait_for(3);
        idle(DEF2);
        pulse_act();
        chk("R11", "activity beats timeout on expiry edge", int'(link_state), 2);

        cur_req = "R12";
        wr(2, 0);
        wr(3, 9);
        rd(3, v); chk("R12", "idle2 readback", v, 9);
        rd(2, v); chk("R12", "idle1 readback", v, 0);
        rd(1, v); chk("R12", "control reads zero", v, 0);
        rd(0, v); chk("R12", "status holds M0", v, 2);
        idle(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule